// File: doc/BRIEF.md
# Isolated Configurable I/O Tile Array

This block sits between an embedded programmable fabric and the host side of a chip. It holds one bidirectional cell per internal lane. A serial configuration chain sets each cell's direction. In output mode the fabric drives the lane toward the host. In input mode the host drives the lane into the fabric. Each cell forces to 0 the data path it does not use, so an undriven or unknown value never crosses the boundary.

A global active-low isolation input overrides every stored direction and forces all cells to input. A small release state machine has two states, `ST_HOLD` and `ST_LIVE`. Reset and isolation hold the array in `ST_HOLD`, where every cell is an input. The transition `HOLD_TO_LIVE` is taken on the first clock edge at which the isolation input is seen high. The transition `LIVE_TO_HOLD` is taken on any edge at which it is seen low. Asserting isolation acts at once, without waiting for a clock. Releasing it takes effect one edge later, so the stored directions only appear after a full cycle with clean inputs.

A single mode bit sends the whole lane group either to a memory-mapped bus side or to a logic-analyzer side. The logic-analyzer vectors are wider than the lane group. Their upper bits carry fabric monitor signals.

Top module: `iso_io_tile_array`

## Requirements
- R1: While `rst_n` is low, every configuration bit is 0 and the state is `ST_HOLD`. Every lane is then an input, whatever `iso_n` does, so no lane drives toward the host.
- R2: On each clock edge with `cfg_en` high, the chain shifts by one place. `cfg_sd` enters at lane LANES-1 and each bit moves one lane lower, so the first of LANES bits shifted in lands in lane 0. `cfg_so` shows lane 0's bit. With `cfg_en` low, the stored bits do not change.
- R3: While `iso_n` is low, every lane is an input. This acts in the same cycle, without waiting for a clock edge, whatever the stored bits are.
- R4: After `iso_n` rises, lanes stay inputs until the next clock edge. From that edge on, a lane whose stored bit is 1 is an output and a lane whose stored bit is 0 is an input.
- R5: For a lane in output mode, the host-side value equals `fab_out` for that lane, and `fab_in` for that lane is 0.
- R6: For a lane in input mode, the host-side value is 0, and `fab_in` for that lane equals the host-side input of the selected interface.
- R7: With `mode_sel` = 0 (bus side), `bus_to_host` carries the lane values and `bus_from_host` feeds the lanes. `la_to_host` and `la_oe` are all 0, and `la_from_host` has no effect.
- R8: With `mode_sel` = 1 (analyzer side), `la_to_host[LANES-1:0]` carries the lane values and `la_to_host[LA_W-1:LANES]` carries `mon_sig`. `la_oe[LANES-1:0]` is 1 exactly for the lanes in output mode, and `la_oe[LA_W-1:LANES]` is all 1. `la_from_host` feeds the lanes, `bus_to_host` is 0, and `bus_from_host` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iso_n | input | 1 | Active-low isolation; low forces all lanes to input |
| mode_sel | input | 1 | Interface select: 0 bus side, 1 analyzer side |
| cfg_sd | input | 1 | Configuration chain serial data in |
| cfg_en | input | 1 | Configuration chain shift enable |
| cfg_so | output | 1 | Configuration chain serial data out (lane 0 bit) |
| fab_out | input | LANES | Fabric-driven lane values |
| fab_in | output | LANES | Gated lane values into the fabric |
| mon_sig | input | LA_W-LANES | Fabric monitor signals for the analyzer side |
| bus_from_host | input | LANES | Bus-side lane inputs |
| bus_to_host | output | LANES | Bus-side lane outputs |
| la_from_host | input | LANES | Analyzer-side lane inputs |
| la_to_host | output | LA_W | Analyzer-side outputs: lanes, then monitors |
| la_oe | output | LA_W | Analyzer-side per-bit output enable |

## Verification
The gating is tried in both interface modes with two configuration patterns. One is sparse and irregular, and the other sets every lane to output. The lane data patterns are chosen so that each lane differs between the fabric side and the host side, so a path that takes its value from the wrong side shows up. While one interface is selected, the inputs of the other are changed, to show that the unselected side has no effect. Isolation is dropped and raised between clock edges and checked before and after the next edge. This separates the immediate override from the one-cycle release. A reload of the chain while lanes are live checks both the shift order and the read-out on `cfg_so`.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;

    // release sequencer states
    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_LIVE = 1'b1
    } iso_state_e;

endpackage

// File: rtl/iso_cfg_chain.sv
module iso_cfg_chain #(
    parameter int LANES = 115
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_sd,
    output logic [LANES-1:0] cfg_q,
    output logic             cfg_so
);

    logic [LANES-1:0] chain_q;

    // new bit enters at the top lane and walks down toward lane 0
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (cfg_en) begin
            chain_q <= {cfg_sd, chain_q[LANES-1:1]};
        end
    end

    assign cfg_q  = chain_q;
    assign cfg_so = chain_q[0];

endmodule

// File: rtl/iso_release_fsm.sv
module iso_release_fsm
    import iso_io_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iso_n,
    output logic drive_ok
);

    iso_state_e state_q;
    iso_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        drive_ok = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                if (iso_n) begin
                    state_d = ST_LIVE;   // HOLD_TO_LIVE
                end
            end
            ST_LIVE: begin
                drive_ok = iso_n;        // isolation wins at once
                if (!iso_n) begin
                    state_d = ST_HOLD;   // LIVE_TO_HOLD
                end
            end
            default: begin
                state_d = ST_HOLD;
            end
        endcase
    end

endmodule

// File: rtl/iso_io_cell.sv
module iso_io_cell (
    input  logic oe,
    input  logic fab_out,
    input  logic sys_in,
    output logic sys_out,
    output logic fab_in
);

    // each direction is forced to 0 when the other one owns the lane
    always_comb begin
        sys_out = oe ? fab_out : 1'b0;
        fab_in  = oe ? 1'b0    : sys_in;
    end

endmodule

// File: rtl/iso_lane_steer.sv
module iso_lane_steer #(
    parameter int LANES = 115,
    parameter int LA_W  = 128
) (
    input  logic                  mode_sel,
    input  logic [LANES-1:0]      sys_out,
    input  logic [LANES-1:0]      oe,
    input  logic [LA_W-LANES-1:0] mon_sig,
    input  logic [LANES-1:0]      bus_from_host,
    input  logic [LANES-1:0]      la_from_host,
    output logic [LANES-1:0]      sys_in,
    output logic [LANES-1:0]      bus_to_host,
    output logic [LA_W-1:0]       la_to_host,
    output logic [LA_W-1:0]       la_oe
);

    localparam int MON_W = LA_W - LANES;

    always_comb begin
        sys_in      = '0;
        bus_to_host = '0;
        la_to_host  = '0;
        la_oe       = '0;
        if (mode_sel) begin
            sys_in     = la_from_host;
            la_to_host = {mon_sig, sys_out};
            la_oe      = {{MON_W{1'b1}}, oe};
        end else begin
            sys_in      = bus_from_host;
            bus_to_host = sys_out;
        end
    end

endmodule

// File: rtl/iso_io_tile_array.sv
module iso_io_tile_array #(
    parameter int LANES = 115,
    parameter int LA_W  = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iso_n,
    input  logic                  mode_sel,
    input  logic                  cfg_sd,
    input  logic                  cfg_en,
    output logic                  cfg_so,
    input  logic [LANES-1:0]      fab_out,
    output logic [LANES-1:0]      fab_in,
    input  logic [LA_W-LANES-1:0] mon_sig,
    input  logic [LANES-1:0]      bus_from_host,
    output logic [LANES-1:0]      bus_to_host,
    input  logic [LANES-1:0]      la_from_host,
    output logic [LA_W-1:0]       la_to_host,
    output logic [LA_W-1:0]       la_oe
);

    logic [LANES-1:0] cfg_q;
    logic [LANES-1:0] oe_eff;
    logic [LANES-1:0] sys_out;
    logic [LANES-1:0] sys_in;
    logic             drive_ok;

    iso_cfg_chain #(.LANES(LANES)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_en (cfg_en),
        .cfg_sd (cfg_sd),
        .cfg_q  (cfg_q),
        .cfg_so (cfg_so)
    );

    iso_release_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .iso_n    (iso_n),
        .drive_ok (drive_ok)
    );

    assign oe_eff = drive_ok ? cfg_q : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_cell
        iso_io_cell u_cell (
            .oe      (oe_eff[g]),
            .fab_out (fab_out[g]),
            .sys_in  (sys_in[g]),
            .sys_out (sys_out[g]),
            .fab_in  (fab_in[g])
        );
    end

    iso_lane_steer #(.LANES(LANES), .LA_W(LA_W)) u_steer (
        .mode_sel      (mode_sel),
        .sys_out       (sys_out),
        .oe            (oe_eff),
        .mon_sig       (mon_sig),
        .bus_from_host (bus_from_host),
        .la_from_host  (la_from_host),
        .sys_in        (sys_in),
        .bus_to_host   (bus_to_host),
        .la_to_host    (la_to_host),
        .la_oe         (la_oe)
    );

endmodule

// File: rtl/iso_io_tile_array_chk.sv
module iso_io_tile_array_chk #(
    parameter int LANES = 115,
    parameter int LA_W  = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iso_n,
    input logic             mode_sel,
    input logic             cfg_en,
    input logic             cfg_sd,
    input logic [LANES-1:0] cfg_q,
    input logic [LANES-1:0] oe_eff,
    input logic [LANES-1:0] sys_out,
    input logic [LANES-1:0] fab_in,
    input logic [LANES-1:0] bus_to_host,
    input logic [LA_W-1:0]  la_to_host,
    input logic [LA_W-1:0]  la_oe
);

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_q == '0 && oe_eff == '0));

    // R2
    cfg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_q[LANES-1] == $past(cfg_sd)));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q));

    // R3
    iso_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_n |-> (oe_eff == '0));

    // R4
    release_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iso_n) |-> (oe_eff == '0));

    // R4
    release_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_n && $past(iso_n) && $past(rst_n)) |-> (oe_eff == cfg_q));

    // R5
    out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fab_in & oe_eff) == '0);

    // R6
    in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_out & ~oe_eff) == '0);

    // R7
    bus_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |-> (la_to_host == '0 && la_oe == '0));

    // R8
    la_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel |-> (bus_to_host == '0 && la_oe[LANES-1:0] == oe_eff));

endmodule

bind iso_io_tile_array iso_io_tile_array_chk #(.LANES(LANES), .LA_W(LA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iso_n       (iso_n),
    .mode_sel    (mode_sel),
    .cfg_en      (cfg_en),
    .cfg_sd      (cfg_sd),
    .cfg_q       (cfg_q),
    .oe_eff      (oe_eff),
    .sys_out     (sys_out),
    .fab_in      (fab_in),
    .bus_to_host (bus_to_host),
    .la_to_host  (la_to_host),
    .la_oe       (la_oe)
);

// File: tb/tb_iso_io_tile_array.sv
`timescale 1ns/100ps
module tb_iso_io_tile_array;

    localparam int L  = 115;
    localparam int LA = 128;
    localparam int MW = LA - L;

    logic          clk = 1'b0;
    logic          rst_n, iso_n, mode_sel, cfg_sd, cfg_en, cfg_so;
    logic [L-1:0]  fab_out, fab_in, bus_from_host, bus_to_host, la_from_host;
    logic [MW-1:0] mon_sig;
    logic [LA-1:0] la_to_host, la_oe;

    always #2.5 clk = ~clk;

    iso_io_tile_array #(.LANES(L), .LA_W(LA)) dut (
        .clk(clk), .rst_n(rst_n), .iso_n(iso_n), .mode_sel(mode_sel),
        .cfg_sd(cfg_sd), .cfg_en(cfg_en), .cfg_so(cfg_so),
        .fab_out(fab_out), .fab_in(fab_in), .mon_sig(mon_sig),
        .bus_from_host(bus_from_host), .bus_to_host(bus_to_host),
        .la_from_host(la_from_host), .la_to_host(la_to_host), .la_oe(la_oe)
    );

    typedef struct {
        string         req;
        logic [L-1:0]  bus;
        logic [LA-1:0] la;
        logic [LA-1:0] laoe;
        logic [L-1:0]  fin;
        logic          so;
    } item_t;

    item_t        sb_q[$];
    event         pushed;
    int           checks = 0;
    int           errors = 0;
    logic [L-1:0] m_cfg  = '0;
    logic         m_live = 1'b0;

    function automatic logic [L-1:0] pat(input logic [31:0] w);
        logic [127:0] t;
        t = {4{w}};
        return t[L-1:0];
    endfunction

    // bench model of the chain and release state, built from R1, R2, R4
    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_cfg  = '0;
            m_live = 1'b0;
        end else begin
            if (cfg_en) m_cfg = {cfg_sd, m_cfg[L-1:1]};
            m_live = iso_n;
        end
        #1;
    endtask

    // driver: computes the expected item from R3..R8 and queues it
    task automatic expect_now(input string req);
        item_t        it;
        logic [L-1:0] oe, so_v, si;
        oe   = (rst_n && m_live && iso_n) ? m_cfg : '0;
        so_v = fab_out & oe;
        si   = mode_sel ? la_from_host : bus_from_host;
        it.req  = req;
        it.bus  = mode_sel ? '0 : so_v;
        it.la   = mode_sel ? {mon_sig, so_v} : '0;
        it.laoe = mode_sel ? {{MW{1'b1}}, oe} : '0;
        it.fin  = si & ~oe;
        it.so   = m_cfg[0];
        #0.2;
        sb_q.push_back(it);
        -> pushed;
        #0.6;
    endtask

    // monitor: pops and compares against the ports
    initial begin
        forever begin
            @(pushed);
            #0.3;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (bus_to_host !== it.bus || la_to_host !== it.la ||
                    la_oe !== it.laoe || fab_in !== it.fin || cfg_so !== it.so) begin
                    errors++;
                    $display("FAIL %s: bus=%h/%h la=%h/%h oe=%h/%h fin=%h/%h so=%b/%b (actual/expected)",
                             it.req, bus_to_host, it.bus, la_to_host, it.la,
                             la_oe, it.laoe, fab_in, it.fin, cfg_so, it.so);
                end
            end
        end
    end

    task automatic load_cfg(input logic [L-1:0] p);
        for (int i = 0; i < L; i++) begin
            cfg_sd = p[i];
            cfg_en = 1'b1;
            tick();
        end
        cfg_en = 1'b0;
    endtask

    logic [L-1:0] pa, pb;
    bit           done = 0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < L; i++) begin
            pa[i] = (i % 3 == 0) || (i == L - 1) || (i % 7 == 2);
            pb[i] = (i % 2 == 1) || (i == 0);
        end
        rst_n = 1'b0; iso_n = 1'b1; mode_sel = 1'b1; cfg_sd = 1'b1; cfg_en = 1'b1;
        fab_out = '1; mon_sig = 13'h15A3;
        bus_from_host = pat(32'h3C96_A50F); la_from_host = pat(32'hC369_5AF0);
        #1;
        tick(); tick(); tick();
        expect_now("R1 reset isolates");
        rst_n = 1'b1; iso_n = 1'b0; cfg_en = 1'b0;
        tick();
        expect_now("R3 isolated after reset");

        load_cfg(pa);
        expect_now("R3 isolation beats loaded bits (R2 so)");
        cfg_sd = 1'b1; tick(); cfg_sd = 1'b0; tick(); cfg_sd = 1'b1; tick();
        expect_now("R2 hold with enable low");

        iso_n = 1'b1;
        expect_now("R4 lanes still inputs before edge");
        tick();
        expect_now("R4 stored directions after edge");

        fab_out = pat(32'h9A5C_3E71);
        expect_now("R5 R6 R8 analyzer pattern A");
        bus_from_host = ~bus_from_host;
        expect_now("R8 bus input ignored");
        fab_out = ~fab_out; la_from_host = ~la_from_host; mon_sig = ~mon_sig;
        expect_now("R5 R6 R8 analyzer pattern B");

        mode_sel = 1'b0;
        expect_now("R7 bus side");
        la_from_host = pat(32'h0F0F_6699);
        expect_now("R7 analyzer input ignored");
        fab_out = '1; bus_from_host = '1;
        expect_now("R5 R6 R7 all ones");

        iso_n = 1'b0;
        expect_now("R3 immediate isolation");
        tick();
        expect_now("R3 isolation held");
        iso_n = 1'b1;
        expect_now("R4 release lag");
        tick();
        expect_now("R4 release taken");

        mode_sel = 1'b1;
        for (int i = 0; i < 40; i++) begin
            cfg_sd = pb[i]; cfg_en = 1'b1; tick();
        end
        cfg_en = 1'b0;
        expect_now("R2 partial reload live");
        for (int i = 40; i < L; i++) begin
            cfg_sd = pb[i]; cfg_en = 1'b1; tick();
        end
        cfg_en = 1'b0;
        expect_now("R2 full reload order");
        fab_out = pat(32'h5D2B_71C4);
        expect_now("R5 R6 pattern on reload");

        load_cfg('1);
        fab_out = pat(32'hE17A_0C3B);
        expect_now("R5 R8 all lanes output");
        mode_sel = 1'b0;
        expect_now("R5 R7 all lanes output bus");

        load_cfg('0);
        expect_now("R6 R7 all lanes input");

        #2;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule